// File: doc/BRIEF.md
# Packet transmit framer

This block turns a payload held in a 16-bit-wide transmit buffer into a complete byte stream for a short-range radio modem. When the host raises the enable input, the framer latches the payload length and sends a run of preamble bytes, a start delimiter and a length byte. It then sends the payload, unpacked from buffer words, and a two-byte frame check that it computes as the payload goes out. When the receiving stage has accepted the last check byte, it raises an interrupt.

Bytes leave on a valid/ready handshake, so a slower downstream stage can stall the stream at any byte. The enable input is level-sensitive. A rising edge starts a packet, and the enable must stay high until the interrupt appears. Dropping it at any point returns the block to idle. A start with an illegal length sends nothing and raises an error flag instead. The buffer read port is combinational: `buf_rdata` must show the word at `buf_addr` in the same cycle.

Top module: `txf_framer`

## Requirements
- R1: In the cycle after a rising edge of `start_en` with a legal length, `busy` and `out_valid` are 1. The stream then carries 4 bytes of 0x00 followed by the delimiter byte 0xA7.
- R2: The byte after the delimiter equals the latched payload length plus 2.
- R3: Payload byte i is taken from buffer word i/2 at address i/2. Bits [7:0] are used for even i and bits [15:8] for odd i. An odd length uses only the low byte of the last word.
- R4: After the payload come two check bytes, low byte first. The check is a CRC-16 with polynomial x^16+x^12+x^5+1, processed LSB first (reversed constant 0x8408), with initial value 0 and no final inversion. It covers the payload bytes only. For the payload "123456789" the check bytes are 0x89 and then 0x21.
- R5: While `out_valid` is 1 and `out_ready` is 0, the byte on `out_data` holds. Every byte is sent exactly once.
- R6: `done_irq` rises in the cycle after the last check byte is accepted, and `busy` falls in that same cycle. `done_irq` stays high while `start_en` stays high.
- R7: `start_en` low at a clock edge leaves `busy`, `out_valid` and `done_irq` at 0 after that edge. This holds even when the edge would also accept the last byte.
- R8: A rising edge of `start_en` with a length of 0 or above 125 sends nothing and keeps `busy` at 0. It sets `len_err`, which stays set until the next accepted start clears it.
- R9: Holding `start_en` high after a packet has completed starts no new packet.
- R10: During and directly after reset, `busy`, `out_valid`, `done_irq` and `len_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_en | input | 1 | Start on rising edge; hold high until done; low aborts |
| pay_len | input | 7 | Payload length in bytes, sampled at the start edge |
| buf_addr | output | 6 | Transmit buffer word address |
| buf_rdata | input | 16 | Buffer word at `buf_addr`, same cycle |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| busy | output | 1 | Packet in progress |
| done_irq | output | 1 | Packet complete interrupt |
| len_err | output | 1 | Last start had an illegal length |

## Verification
Abort and completion can fall in the same cycle. This happens when `start_en` is sampled low at the very edge where the last check byte is handshaken. The bench provokes this by watching its own model until exactly one byte remains with ready high, and then dropping the enable. The abort must win: no interrupt may appear, and the block must return to idle. Stalls of the handshake during every field are also provoked, by alternating and pseudo-random patterns on `out_ready`, and compared cycle by cycle against the model's byte queue.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 16;
    localparam int MAX_PAYLOAD = 125;
    localparam int PRE_BYTES   = 4;
    localparam int FCS_BYTES   = 2;
    localparam int LEN_W       = $clog2(MAX_PAYLOAD + 1);
    localparam int ADDR_W      = LEN_W - 1;
    localparam int CRC_W       = 16;
    localparam logic [CRC_W-1:0]  CRC_POLY_REV = 16'h8408;
    localparam logic [BYTE_W-1:0] PRE_CODE     = 8'h00;
    localparam logic [BYTE_W-1:0] SFD_CODE     = 8'hA7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_LEN,
        ST_PAY,
        ST_FCSL,
        ST_FCSH,
        ST_DONE
    } txf_state_e;

    typedef struct packed {
        txf_state_e       st;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic             en;
        logic             err;
    } seq_regs_t;
endpackage

// File: rtl/txf_byte_pick.sv
module txf_byte_pick #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int LANES  = WORD_W / BYTE_W,
    parameter int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lane_w [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_w[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lane_w[sel_i];
endmodule

// File: rtl/txf_crc16.sv
module txf_crc16 #(
    parameter int              CRC_W  = 16,
    parameter int              DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY  = 16'h8408
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] crc_d, crc_q, step_w;

    always_comb begin
        step_w = crc_q;
        for (int i = 0; i < DATA_W; i++) begin
            if (step_w[0] ^ din_i[i]) step_w = (step_w >> 1) ^ POLY;
            else                      step_w = step_w >> 1;
        end
        crc_d = crc_q;
        if (clr_i)      crc_d = '0;
        else if (upd_i) crc_d = step_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (crc_o == '0));
endmodule

// File: rtl/txf_seq.sv
module txf_seq
    import txf_pkg::*;
#(
    parameter int               PRE_N = PRE_BYTES,
    parameter int               MAX_N = MAX_PAYLOAD,
    parameter logic [BYTE_W-1:0] SFD  = SFD_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_en,
    input  logic [LEN_W-1:0]  pay_len,
    input  logic [BYTE_W-1:0] pay_byte,
    input  logic [CRC_W-1:0]  crc_val,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              lane_sel,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              busy,
    output logic              done_irq,
    output logic              len_err,
    output logic              crc_clr,
    output logic              crc_upd
);
    localparam logic [LEN_W-1:0] PRE_LAST = LEN_W'(PRE_N - 1);
    localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_N);
    localparam seq_regs_t RST_REGS = '{st: ST_IDLE, cnt: '0, len: '0, en: 1'b0, err: 1'b0};

    seq_regs_t d, q;
    logic hs_w, len_bad_w, start_w;

    assign len_bad_w = (pay_len == '0) || (pay_len > LEN_MAX);
    assign start_w   = (q.st == ST_IDLE) && start_en && !q.en;
    assign out_valid = (q.st != ST_IDLE) && (q.st != ST_DONE);
    assign hs_w      = out_valid && out_ready;

    always_comb begin
        d    = q;
        d.en = start_en;
        if (!start_en) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: if (start_w) begin
                    if (len_bad_w) begin
                        d.err = 1'b1;
                    end else begin
                        d.err = 1'b0;
                        d.len = pay_len;
                        d.cnt = '0;
                        d.st  = ST_PRE;
                    end
                end
                ST_PRE: if (hs_w) begin
                    if (q.cnt == PRE_LAST) begin
                        d.cnt = '0;
                        d.st  = ST_SFD;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_SFD:  if (hs_w) d.st = ST_LEN;
                ST_LEN: if (hs_w) begin
                    d.cnt = '0;
                    d.st  = ST_PAY;
                end
                ST_PAY: if (hs_w) begin
                    if (q.cnt == q.len - 1'b1) begin
                        d.cnt = '0;
                        d.st  = ST_FCSL;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_FCSL: if (hs_w) d.st = ST_FCSH;
                ST_FCSH: if (hs_w) d.st = ST_DONE;
                ST_DONE: d.st = ST_DONE;
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_REGS;
        else        q <= d;
    end

    always_comb begin
        unique case (q.st)
            ST_PRE:  out_data = PRE_CODE;
            ST_SFD:  out_data = SFD;
            ST_LEN:  out_data = BYTE_W'(q.len) + BYTE_W'(FCS_BYTES);
            ST_PAY:  out_data = pay_byte;
            ST_FCSL: out_data = crc_val[7:0];
            ST_FCSH: out_data = crc_val[15:8];
            default: out_data = '0;
        endcase
    end

    assign buf_addr = q.cnt[LEN_W-1:1];
    assign lane_sel = q.cnt[0];
    assign busy     = out_valid;
    assign done_irq = (q.st == ST_DONE);
    assign len_err  = q.err;
    assign crc_clr  = start_w && !len_bad_w;
    assign crc_upd  = hs_w && (q.st == ST_PAY);

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done_irq && start_en && !$past(start_en) && (pay_len != '0) && (pay_len <= LEN_MAX))
        |=> (busy && out_valid && out_data == PRE_CODE));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && start_en) |=> (out_valid && $stable(out_data)));

    assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> ($past(out_valid && out_ready) && !busy));

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_en |=> (!busy && !out_valid && !done_irq));

    assert_badlen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done_irq && start_en && !$past(start_en) && ((pay_len == '0) || (pay_len > LEN_MAX)))
        |=> (!busy && len_err));
endmodule

// File: rtl/txf_framer.sv
module txf_framer
    import txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_en,
    input  logic [LEN_W-1:0]  pay_len,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [WORD_W-1:0] buf_rdata,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              busy,
    output logic              done_irq,
    output logic              len_err
);
    logic [BYTE_W-1:0] pay_byte_w;
    logic [CRC_W-1:0]  crc_w;
    logic              lane_w, crc_clr_w, crc_upd_w;

    txf_byte_pick #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pick (
        .word_i (buf_rdata),
        .sel_i  (lane_w),
        .byte_o (pay_byte_w)
    );

    txf_crc16 #(.CRC_W(CRC_W), .DATA_W(BYTE_W), .POLY(CRC_POLY_REV)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (crc_clr_w),
        .upd_i (crc_upd_w),
        .din_i (out_data),
        .crc_o (crc_w)
    );

    txf_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_en  (start_en),
        .pay_len   (pay_len),
        .pay_byte  (pay_byte_w),
        .crc_val   (crc_w),
        .out_ready (out_ready),
        .buf_addr  (buf_addr),
        .lane_sel  (lane_w),
        .out_data  (out_data),
        .out_valid (out_valid),
        .busy      (busy),
        .done_irq  (done_irq),
        .len_err   (len_err),
        .crc_clr   (crc_clr_w),
        .crc_upd   (crc_upd_w)
    );
endmodule

// File: tb/txf_framer_test.sv
module txf_framer_test;
    import txf_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              start_en = 1'b0;
    logic [LEN_W-1:0]  pay_len = '0;
    logic [ADDR_W-1:0] buf_addr;
    logic [WORD_W-1:0] buf_rdata;
    logic [BYTE_W-1:0] out_data;
    logic              out_valid, busy, done_irq, len_err;
    logic              out_ready = 1'b0;

    logic [WORD_W-1:0] mem [0:(1<<ADDR_W)-1];
    assign buf_rdata = mem[buf_addr];

    txf_framer uut (
        .clk(clk), .rst_n(rst_n), .start_en(start_en), .pay_len(pay_len),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .busy(busy),
        .done_irq(done_irq), .len_err(len_err)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    finished = 1'b0;
    string cur_tag = "R10";

    logic [7:0] m_q[$];
    string      m_tag[$];
    logic [7:0] cap_q[$];
    bit         m_active = 1'b0, m_irq = 1'b0, m_err = 1'b0, m_en_prev = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (((r ^ 16'(b >> i)) & 16'h1) != 0) r = (r >> 1) ^ 16'h8408;
            else                                  r = r >> 1;
        end
        return r;
    endfunction

    task automatic build_frame(int len);
        logic [15:0] c = 16'h0000;
        logic [7:0]  b;
        m_q.delete();
        m_tag.delete();
        for (int i = 0; i < 4; i++) begin m_q.push_back(8'h00); m_tag.push_back("R1"); end
        m_q.push_back(8'hA7); m_tag.push_back("R1");
        m_q.push_back(8'(len + 2)); m_tag.push_back("R2");
        for (int i = 0; i < len; i++) begin
            b = (i % 2 == 1) ? mem[i/2][15:8] : mem[i/2][7:0];
            m_q.push_back(b); m_tag.push_back("R3");
            c = crc_byte(c, b);
        end
        m_q.push_back(c[7:0]);  m_tag.push_back("R4");
        m_q.push_back(c[15:8]); m_tag.push_back("R4");
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_irq = 0; m_err = 0; m_en_prev = 0;
            m_q.delete(); m_tag.delete();
        end else begin
            if (!start_en) begin
                m_active = 0; m_irq = 0;
                m_q.delete(); m_tag.delete();
            end else if (!m_active && !m_irq && !m_en_prev) begin
                if (pay_len == 0 || pay_len > 125) begin
                    m_err = 1;
                end else begin
                    m_err = 0;
                    build_frame(int'(pay_len));
                    m_active = 1;
                end
            end else if (m_active && out_ready) begin
                void'(m_q.pop_front());
                void'(m_tag.pop_front());
                if (m_q.size() == 0) begin
                    m_active = 0;
                    m_irq = 1;
                end
            end
            m_en_prev = start_en;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!finished) begin
            check(cur_tag, "busy", int'(busy), int'(m_active));
            check(cur_tag, "out_valid", int'(out_valid), int'(m_active));
            check(cur_tag == "R7" ? "R7" : "R6", "done_irq", int'(done_irq), int'(m_irq));
            check(cur_tag == "R10" ? "R10" : "R8", "len_err", int'(len_err), int'(m_err));
            if (m_active && out_valid) begin
                check(out_ready ? m_tag[0] : "R5", "out_data", int'(out_data), int'(m_q[0]));
                if (out_ready && start_en) cap_q.push_back(out_data);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL R6 watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic pick_ready(int mode);
        if (mode == 0) return 1'b1;
        if (mode == 1) return cyc[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0] | lfsr[3];
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic send(int len, int mode, string tag);
        int guard = 0;
        cur_tag = tag;
        tick();
        cap_q.delete();
        pay_len = LEN_W'(len);
        start_en = 1'b1;
        out_ready = pick_ready(mode);
        do begin
            tick();
            out_ready = pick_ready(mode);
            guard++;
        end while (!m_irq && guard < 5000);
        cur_tag = "R9";
        for (int i = 0; i < 20; i++) tick();
        check("R9", "no restart busy", int'(busy), 0);
        check("R6", "irq held", int'(done_irq), 1);
        start_en = 1'b0;
        cur_tag = tag;
        tick();
        tick();
    endtask

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
        repeat (3) tick();
        check("R10", "busy in reset", int'(busy), 0);
        check("R10", "irq in reset", int'(done_irq), 0);
        rst_n = 1'b1;
        tick();
        check("R10", "valid after reset", int'(out_valid), 0);
        check("R10", "err after reset", int'(len_err), 0);

        send(1, 0, "R1");
        send(4, 1, "R5");
        send(125, 2, "R5");
        send(6, 2, "R3");

        mem[0] = {8'h32, 8'h31}; mem[1] = {8'h34, 8'h33};
        mem[2] = {8'h36, 8'h35}; mem[3] = {8'h38, 8'h37};
        mem[4] = {8'hEE, 8'h39};
        send(9, 0, "R4");
        check("R4", "capture count", cap_q.size(), 17);
        if (cap_q.size() == 17) begin
            check("R4", "known check low", int'(cap_q[15]), 'h89);
            check("R4", "known check high", int'(cap_q[16]), 'h21);
            check("R2", "known length byte", int'(cap_q[5]), 11);
        end

        // illegal lengths
        cur_tag = "R8";
        pay_len = '0; start_en = 1'b1;
        repeat (3) tick();
        check("R8", "len 0 err", int'(len_err), 1);
        check("R8", "len 0 busy", int'(busy), 0);
        start_en = 1'b0; tick();
        pay_len = LEN_W'(126); start_en = 1'b1;
        repeat (3) tick();
        check("R8", "len 126 err", int'(len_err), 1);
        check("R8", "len 126 valid", int'(out_valid), 0);
        start_en = 1'b0; tick();
        send(2, 0, "R8");
        check("R8", "err cleared", int'(len_err), 0);

        // abort in the middle of the payload
        cur_tag = "R7";
        pay_len = LEN_W'(10); start_en = 1'b1; out_ready = 1'b1;
        repeat (12) tick();
        start_en = 1'b0;
        tick();
        check("R7", "abort busy", int'(busy), 0);
        check("R7", "abort valid", int'(out_valid), 0);
        tick();
        send(3, 0, "R7");

        // abort on the edge that takes the last byte
        cur_tag = "R7";
        pay_len = LEN_W'(2); start_en = 1'b1; out_ready = 1'b1;
        for (int g = 0; g < 100 && !(m_active && m_q.size() == 1); g++) tick();
        start_en = 1'b0;
        tick();
        check("R7", "same-cycle abort irq", int'(done_irq), 0);
        tick();
        check("R7", "same-cycle abort busy", int'(busy), 0);
        send(5, 1, "R1");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule